// File: doc/BRIEF.md
# Interleaved Complex Tone Generator

This block synthesizes a fixed-frequency complex sinusoid and delivers it on a single signed sample bus. On each clock it emits one component of the current complex sample, the cosine (in-phase) part and then the sine (quadrature) part. A converter interface that expects the two components interleaved on one bus can take the output directly. A one-bit selector toggles on every enabled clock. The tone's phase index moves forward once per pair of clocks, so the tone update rate is half the clock rate.

One tone period is a fixed 100 phase steps. The generator therefore produces a tone at the clock rate divided by 200. For example, a 20 MHz clock gives 10 M complex samples per second and a 100 kHz tone. Sample values are read from a table computed at elaboration. The table holds cosine and sine scaled by 2047 in a signed 12-bit format with 11 fractional bits, which keeps the values clear of the asymmetric negative limit.

The enable input pauses generation without losing phase. Synchronous reset restarts the tone at phase zero with the in-phase component first.

Top module: `iqtone_gen`

## Requirements
- R1: While reset is high at a clock edge, the next outputs are sampleOut = 0, qFlag = 0 and sampleValid = 0, and the phase index and selector return to 0. The first valid output after reset is the in-phase sample of phase 0, which is 2047.
- R2: On consecutive enabled clocks, qFlag alternates 0, 1, 0, 1, starting at 0. qFlag = 0 marks an in-phase sample and qFlag = 1 marks a quadrature sample.
- R3: With qFlag = 0 the bus carries round(2047*cos(2*pi*k/100)). With qFlag = 1 it carries round(2047*sin(2*pi*k/100)). Here k is the current phase index.
- R4: Both samples of a pair share one phase index. The index advances only on the enabled clock that outputs the quadrature sample.
- R5: The phase index runs from 0 to 99 and wraps to 0. After 200 enabled clocks the output sequence repeats.
- R6: When enable is low at a clock edge, sampleValid goes low in the next cycle, and sampleOut, qFlag, the selector and the phase index hold their values.
- R7: The output is registered. The sample chosen by the selector state at an enabled edge appears, with sampleValid high, in the cycle that follows that edge, and qFlag describes that same sample.
- R8: Samples are signed 12-bit two's complement with 11 fractional bits. A valid sample never exceeds 2047 in magnitude, so -2048 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low pauses generation |
| sampleOut | output | 12 | Interleaved signed sample, 11 fractional bits |
| qFlag | output | 1 | 0 = in-phase sample, 1 = quadrature sample |
| sampleValid | output | 1 | High in the cycle after an enabled clock |

## Verification
The embedded properties check the cycle-local rules on every clock: the selector toggles on enabled edges, the phase index stays inside the period and does not move on an in-phase edge, state and data freeze while enable is low, a valid strobe follows each enabled edge, and the negative limit never appears. What no single-cycle property can show is left to the bench scenarios. These are the actual trigonometric values at each phase, the return to the starting sample after a full 200-clock period, and the restart at phase zero after a reset that lands in the middle of a run. The bench checks them against a reference model fed with random enable and reset patterns, together with directed points at the quarter, half and full period.

// File: rtl/iqtone_pkg.sv
package iqtone_pkg;

  // Strobes handed from the sequencing logic to the output datapath
  typedef struct packed {
    logic capture;  // load a new sample into the output register
    logic isQ;      // the sample being loaded is the quadrature part
  } strobes_t;

  localparam real TWO_PI = 6.283185307179586;

endpackage

// File: rtl/iqtone_ctrl.sv
module iqtone_ctrl
  import iqtone_pkg::*;
#(
  parameter int PERIOD  = 100,
  parameter int PHASE_W = $clog2(PERIOD)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  output logic [PHASE_W-1:0] phase,
  output strobes_t           strobes
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(PERIOD - 1);

  logic sel;

  // Selector toggles every enabled clock; the phase moves after the Q sample
  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= 1'b0;
      phase <= '0;
    end else if (en) begin
      sel <= ~sel;
      if (sel) begin
        phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.capture = en;
    strobes.isQ     = sel;
  end

  // R2
  sel_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (sel != $past(sel)));

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_PHASE);

  // R4
  phase_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !sel) |=> (phase == $past(phase)));

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(sel) && $stable(phase)));

endmodule

// File: rtl/iqtone_rom.sv
module iqtone_rom
  import iqtone_pkg::*;
#(
  parameter int PERIOD   = 100,
  parameter int SAMPLE_W = 12,
  parameter int AMP      = 2047,
  parameter int PHASE_W  = $clog2(PERIOD)
) (
  input  logic [PHASE_W-1:0]         phase,
  output logic signed [SAMPLE_W-1:0] cosVal,
  output logic signed [SAMPLE_W-1:0] sinVal
);

  logic signed [SAMPLE_W-1:0] cosTab [PERIOD];
  logic signed [SAMPLE_W-1:0] sinTab [PERIOD];

  // Table contents are computed at elaboration, rounded half away from zero
  for (genvar k = 0; k < PERIOD; k++) begin : g_entry
    localparam real ANGLE = TWO_PI * real'(k) / real'(PERIOD);
    localparam real COS_R = real'(AMP) * $cos(ANGLE);
    localparam real SIN_R = real'(AMP) * $sin(ANGLE);
    localparam int  COS_I = (COS_R >= 0.0) ? $rtoi(COS_R + 0.5) : -$rtoi(0.5 - COS_R);
    localparam int  SIN_I = (SIN_R >= 0.0) ? $rtoi(SIN_R + 0.5) : -$rtoi(0.5 - SIN_R);
    assign cosTab[k] = SAMPLE_W'(COS_I);
    assign sinTab[k] = SAMPLE_W'(SIN_I);
  end

  assign cosVal = cosTab[phase];
  assign sinVal = sinTab[phase];

endmodule

// File: rtl/iqtone_datapath.sv
module iqtone_datapath
  import iqtone_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobes_t                   strobes,
  input  logic signed [SAMPLE_W-1:0] cosVal,
  input  logic signed [SAMPLE_W-1:0] sinVal,
  output logic signed [SAMPLE_W-1:0] sampleOut,
  output logic                       qFlag,
  output logic                       sampleValid
);

  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [SAMPLE_W-1:0] picked;

  assign picked = strobes.isQ ? sinVal : cosVal;

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleOut   <= '0;
      qFlag       <= 1'b0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobes.capture;
      if (strobes.capture) begin
        sampleOut <= picked;
        qFlag     <= strobes.isQ;
      end
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> (sampleOut != MOST_NEG));

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> sampleValid);

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> ($stable(sampleOut) && $stable(qFlag) && !sampleValid));

endmodule

// File: rtl/iqtone_gen.sv
module iqtone_gen
  import iqtone_pkg::*;
#(
  parameter int PERIOD   = 100,
  parameter int SAMPLE_W = 12,
  parameter int AMP      = 2047
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  output logic signed [SAMPLE_W-1:0] sampleOut,
  output logic                       qFlag,
  output logic                       sampleValid
);

  localparam int PHASE_W = $clog2(PERIOD);

  logic [PHASE_W-1:0]         phase;
  strobes_t                   strobes;
  logic signed [SAMPLE_W-1:0] cosVal;
  logic signed [SAMPLE_W-1:0] sinVal;

  iqtone_ctrl #(
    .PERIOD (PERIOD),
    .PHASE_W(PHASE_W)
  ) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .phase  (phase),
    .strobes(strobes)
  );

  iqtone_rom #(
    .PERIOD  (PERIOD),
    .SAMPLE_W(SAMPLE_W),
    .AMP     (AMP),
    .PHASE_W (PHASE_W)
  ) i_rom (
    .phase (phase),
    .cosVal(cosVal),
    .sinVal(sinVal)
  );

  iqtone_datapath #(
    .SAMPLE_W(SAMPLE_W)
  ) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .cosVal     (cosVal),
    .sinVal     (sinVal),
    .sampleOut  (sampleOut),
    .qFlag      (qFlag),
    .sampleValid(sampleValid)
  );

endmodule

// File: tb/test_iqtone_gen.sv
`timescale 1ns/1ps
module test_iqtone_gen;

  localparam int  PERIOD = 100;
  localparam real TWOPI  = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [11:0] sampleOut;
  logic qFlag;
  logic sampleValid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int cycles = 0;

  // Reference model state
  int mPhase = 0;
  bit mSel   = 1'b0;
  int expData  = 0;
  bit expFlag  = 1'b0;
  bit expValid = 1'b0;

  always #4 clk = ~clk;

  iqtone_gen i_iqtone_gen (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .sampleOut  (sampleOut),
    .qFlag      (qFlag),
    .sampleValid(sampleValid)
  );

  function automatic int roundAmp(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
  endfunction

  function automatic int refCos(int k);
    return roundAmp(2047.0 * $cos(TWOPI * real'(k) / real'(PERIOD)));
  endfunction

  function automatic int refSin(int k);
    return roundAmp(2047.0 * $sin(TWOPI * real'(k) / real'(PERIOD)));
  endfunction

  // Reference model advanced on each rising edge from the requirements
  always @(posedge clk) begin
    cycles = cycles + 1;
    if (rst) begin
      mPhase = 0; mSel = 1'b0;
      expData = 0; expFlag = 1'b0; expValid = 1'b0;        // R1
    end else if (en) begin
      expData  = mSel ? refSin(mPhase) : refCos(mPhase);   // R3
      expFlag  = mSel;                                     // R2
      expValid = 1'b1;                                     // R7
      if (mSel) mPhase = (mPhase == PERIOD - 1) ? 0 : mPhase + 1; // R4 R5
      mSel = ~mSel;
    end else begin
      expValid = 1'b0;                                     // R6
    end
  end

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, actual, expected, cycles);
    end
  endtask

  task automatic checkModel();
    check("R7 valid", int'(sampleValid), int'(expValid));
    check("R2 flag", int'(qFlag), int'(expFlag));
    check("R3 data", int'(sampleOut), expData);
    if (sampleValid) check("R8 range", int'(sampleOut == -12'sd2048), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // Reset state
    rst = 1'b1; en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset data", int'(sampleOut), 0);
    check("R1 reset flag", int'(qFlag), 0);
    check("R1 reset valid", int'(sampleValid), 0);

    // Continuous run over more than two periods with directed points
    rst = 1'b0; en = 1'b1;
    for (int i = 1; i <= 450; i++) begin
      @(negedge clk);
      checkModel();
      if (i == 1)   begin check("R1 first I", int'(sampleOut), 2047); check("R1 first flag", int'(qFlag), 0); end
      if (i == 2)   check("R3 Q phase0", int'(sampleOut), 0);
      if (i == 52)  check("R3 Q phase25", int'(sampleOut), 2047);
      if (i == 101) check("R4 I phase50", int'(sampleOut), -2047);
      if (i == 201) check("R5 wrap I", int'(sampleOut), 2047);
      if (i == 202) check("R5 wrap Q", int'(sampleOut), 0);
    end

    // Directed pause: everything freezes, then resumes in sequence
    en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      checkModel();
    end
    check("R6 pause valid low", int'(sampleValid), 0);
    en = 1'b1;

    // Reset in the middle of a pair
    @(negedge clk); checkModel();
    rst = 1'b1;
    @(negedge clk); checkModel();
    rst = 1'b0;
    @(negedge clk); checkModel();
    check("R1 restart I phase0", int'(sampleOut), 2047);

    // Random enable and occasional reset
    for (int i = 0; i < 4000; i++) begin
      en  = ($urandom_range(99) < 70);
      rst = ($urandom_range(199) == 0);
      @(negedge clk);
      checkModel();
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Watchdog
  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule